// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter serving up to sixteen analog inputs. It divides the master clock down to a converter clock and runs every conversion as one synchronisation clock, a three-clock sampling window and ten binary-search clocks. During the search it drives a trial code to the DAC and reads a single comparator bit each converter clock. It also steers the input multiplexer through a channel-select output.

A conversion begins on a software start pulse, on a timer trigger pulse, or on a rising edge of an external trigger pin; the timer and pin sources only count when external triggering is enabled and that source is selected. After it starts, the block runs one conversion, runs conversions back to back, or scans an ascending run of channels that begins at channel 1 and ends at the programmed top channel. Results always land in a data register. In buffered mode they are also written around a ring of slots, and those slots are drained through a valid/ready stream.

The stream keeps `res_valid` high and holds `res_data`/`res_ch` steady until `res_ready` is seen. The converter never stalls for the reader. A result that lands on a slot that has not been read replaces that slot's content and raises the sticky overrun flag. While a buffered run is in progress, the mode inputs and the channel field should not change, except for a deliberate channel change, which restarts the run.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `eoc_flag`, `eoc_irq`, `ovr_flag`, `res_valid` and `sample_o` are 0, and `data_out`, `data_ch` and `dac_code` are 0.
- R2: `speed_sel` codes 0 to 7 divide the master clock by 2, 3, 4, 6, 8, 10, 12 and 18. `sample_o` stays high for exactly 3 converter clocks of each conversion.
- R3: The bit decisions form a binary search from MSB to LSB. Each bit is set on trial and then kept if `cmp_in` is 1 on the next converter clock (input at or above the DAC code) or cleared if it is 0. The result is therefore the largest code not above the input.
- R4: In single mode (`cont_mode`=0, `scan_mode`=0) one start gives exactly one conversion on `chan_sel`. `data_out` and `data_ch` then hold the result and its channel, and `busy` returns to 0.
- R5: In continuous mode each conversion follows the previous one at once, so `sample_o` rises every 14 converter clocks.
- R6: In scan mode the channels 1, 2, ... up to `chan_sel` are converted in ascending order (a `chan_sel` of 0 is treated as 1). A single scan then stops.
- R7: In continuous scan mode the sequence wraps from the top channel back to channel 1.
- R8: Starts come from `sw_start`, from `tmr_trig` when `ext_en`=1 and `ext_src`=0, or from a rising edge of `ext_pin` (through a two-stage synchroniser) when `ext_en`=1 and `ext_src`=1. Any other trigger is ignored, and so is any start while `busy`=1.
- R9: A change of `chan_sel` during a conversion aborts it and restarts at once: on the new channel, or at channel 1 in scan mode.
- R10: `eoc_flag` is sticky. It is cleared by `eoc_clr` and a new set wins over the clear. Without buffering it is set by every conversion. `eoc_irq` equals `eoc_flag` AND `eoc_ie`.
- R11: In buffered mode the results fill ring slots in order. The ring length is the scan top channel in scan mode and 16 otherwise. `eoc_flag` is set only by a write to the last slot, and the stream hands the slots out in write order with their channel.
- R12: A buffered write to a slot that is still unread sets the sticky `ovr_flag`, which `ovr_clr` clears. An unread slot that is being popped in the same cycle does not count as overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Software start pulse |
| tmr_trig | input | 1 | Timer trigger-output pulse |
| ext_pin | input | 1 | External trigger pin, asynchronous |
| ext_en | input | 1 | Enables the timer and pin start sources |
| ext_src | input | 1 | 0 selects timer, 1 selects pin |
| cont_mode | input | 1 | Continuous conversion |
| scan_mode | input | 1 | Scan from channel 1 to `chan_sel` |
| buf_mode | input | 1 | Write results into the ring |
| chan_sel | input | 4 | Channel, or scan top channel |
| speed_sel | input | 3 | Converter clock divisor code |
| eoc_clr | input | 1 | Clears the end-of-conversion flag |
| eoc_ie | input | 1 | End-of-conversion interrupt enable |
| ovr_clr | input | 1 | Clears the overrun flag |
| cmp_in | input | 1 | Comparator: input at or above DAC code |
| chan_out | output | 4 | Multiplexer channel select |
| dac_code | output | 10 | Trial code to the DAC |
| sample_o | output | 1 | Sampling window active |
| busy | output | 1 | A conversion run is active |
| eoc_flag | output | 1 | End-of-conversion flag |
| eoc_irq | output | 1 | End-of-conversion interrupt |
| data_out | output | 10 | Latest result |
| data_ch | output | 4 | Channel of the latest result |
| res_valid | output | 1 | Ring head slot is unread |
| res_ready | input | 1 | Reader accepts the head slot |
| res_data | output | 10 | Ring head result |
| res_ch | output | 4 | Ring head channel |
| ovr_flag | output | 1 | Overrun flag |

## Verification
The bench models the comparator as an ideal input voltage per channel, so each result must equal the voltage that was set. Codes 0, 1, 511, 512, 1022 and 1023 are used to catch a search that drops or sticks at the MSB or the LSB. A wrong divisor entry or a sampling window that is too short or too long shows up as a wrong count of `sample_o` cycles, and a wasted clock between conversions shows up as a continuous period that is not 14 converter clocks. The scan tests watch the channel order, the wrap back to channel 1 and a top channel of 0; a design that starts at channel 0 or stops one channel early fails them. Further tests cover:
- gated or mid-conversion triggers that must do nothing;
- a channel change that must restart the conversion, so that a design that finishes the old channel reports the wrong channel;
- an end-of-conversion flag that must stay low until the ring is full;
- an overrun that only appears once the ring has wrapped over an unread slot.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SYNC,
    PH_SAMPLE,
    PH_BITS
  } conv_phase_e;

  localparam int SAMPLE_TICKS = 3;
  localparam int DIV_W        = 5;

  // speed code to master-clock divisor
  function automatic logic [DIV_W-1:0] speed_to_div(input logic [2:0] code);
    logic [DIV_W-1:0] d;
    case (code)
      3'd0:    d = DIV_W'(2);
      3'd1:    d = DIV_W'(3);
      3'd2:    d = DIV_W'(4);
      3'd3:    d = DIV_W'(6);
      3'd4:    d = DIV_W'(8);
      3'd5:    d = DIV_W'(10);
      3'd6:    d = DIV_W'(12);
      default: d = DIV_W'(18);
    endcase
    return d;
  endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] speed_sel,
  output logic       tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div;

  assign div  = speed_to_div(speed_sel);
  assign tick = (cnt >= div - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R2: every divisor is at least 2, so converter ticks never touch
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/adc_start_sel.sv
module adc_start_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_start,
  input  logic tmr_trig,
  input  logic ext_pin,
  input  logic ext_en,
  input  logic ext_src,
  output logic start
);

  logic pin_m, pin_s, pin_d;
  logic pin_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_m <= 1'b0;
      pin_s <= 1'b0;
      pin_d <= 1'b0;
    end else begin
      pin_m <= ext_pin;
      pin_s <= pin_m;
      pin_d <= pin_s;
    end
  end

  assign pin_rise = pin_s & ~pin_d;
  assign start    = sw_start | (ext_en & (ext_src ? pin_rise : tmr_trig));

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_seq_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         go,
  input  logic         cmp_in,
  output logic [W-1:0] dac_code,
  output logic         sampling,
  output logic         done,
  output logic [W-1:0] result
);

  localparam int BW = $clog2(W);
  localparam logic [W-1:0] MSB_TRIAL = {1'b1, {(W-1){1'b0}}};

  conv_phase_e   ph;
  logic [1:0]    scnt;
  logic [BW-1:0] bidx;
  logic [W-1:0]  code;
  logic          in_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      scnt <= '0;
      bidx <= '0;
      code <= '0;
    end else if (go) begin
      ph   <= PH_SYNC;
      scnt <= '0;
      bidx <= '0;
      code <= '0;
    end else if (tick) begin
      case (ph)
        PH_SYNC: begin
          ph   <= PH_SAMPLE;
          scnt <= '0;
        end
        PH_SAMPLE: begin
          if (scnt == 2'(SAMPLE_TICKS - 1)) begin
            ph   <= PH_BITS;
            code <= MSB_TRIAL;
            bidx <= BW'(W - 1);
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        PH_BITS: begin
          code[bidx] <= cmp_in;
          if (bidx == '0) begin
            ph <= PH_IDLE;
          end else begin
            code[bidx - 1'b1] <= 1'b1;
            bidx              <= bidx - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign dac_code = code;
  assign sampling = (ph == PH_SAMPLE);
  assign in_bits  = (ph == PH_BITS);
  assign done     = tick && in_bits && (bidx == '0);
  assign result   = {code[W-1:1], cmp_in};

  // R3: the trial code only moves on a converter clock or a restart
  a_r3_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !go) |=> $stable(dac_code));

  // R3: the search opens with only the MSB set
  a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_bits) |-> (dac_code == MSB_TRIAL));

endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
  parameter int W   = 10,
  parameter int NCH = 16,
  parameter int CHW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [CHW-1:0] wr_ch,
  input  logic         buf_mode,
  input  logic [CHW:0] ring_len,
  input  logic         ovr_clr,
  input  logic         res_ready,
  output logic [W-1:0] data_q,
  output logic [CHW-1:0] data_ch_q,
  output logic         buf_full,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic [CHW-1:0] res_ch,
  output logic         ovr
);

  logic [W-1:0]   mem_d [NCH];
  logic [CHW-1:0] mem_c [NCH];
  logic [NCH-1:0] unread;
  logic [CHW-1:0] wptr, rptr;
  logic           buf_wr, pop, w_last, r_last, ovr_hit;

  assign buf_wr  = wr_en && buf_mode;
  assign pop     = res_valid && res_ready;
  assign w_last  = ({1'b0, wptr} >= ring_len - 1'b1);
  assign r_last  = ({1'b0, rptr} >= ring_len - 1'b1);
  assign buf_full = buf_wr && w_last;
  assign ovr_hit = buf_wr && unread[wptr] && !(pop && (rptr == wptr));

  assign res_valid = unread[rptr];
  assign res_data  = mem_d[rptr];
  assign res_ch    = mem_c[rptr];

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_d[g]  <= '0;
          mem_c[g]  <= '0;
          unread[g] <= 1'b0;
        end else begin
          if (pop && (rptr == CHW'(g))) unread[g] <= 1'b0;
          if (buf_wr && (wptr == CHW'(g))) begin
            mem_d[g]  <= wr_data;
            mem_c[g]  <= wr_ch;
            unread[g] <= 1'b1;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      data_q    <= '0;
      data_ch_q <= '0;
      ovr       <= 1'b0;
    end else begin
      if (wr_en) begin
        data_q    <= wr_data;
        data_ch_q <= wr_ch;
      end
      if (buf_wr) wptr <= w_last ? '0 : wptr + 1'b1;
      if (pop)    rptr <= r_last ? '0 : rptr + 1'b1;
      if (ovr_hit)      ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end

  // R12: overrun stays up until cleared
  a_r12_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr);

  // R11: an offered slot holds until taken or replaced
  a_r11_offer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !wr_en) |=> (res_valid && $stable(res_data)));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int W   = 10,
  parameter int NCH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sw_start,
  input  logic                     tmr_trig,
  input  logic                     ext_pin,
  input  logic                     ext_en,
  input  logic                     ext_src,
  input  logic                     cont_mode,
  input  logic                     scan_mode,
  input  logic                     buf_mode,
  input  logic [$clog2(NCH)-1:0]   chan_sel,
  input  logic [2:0]               speed_sel,
  input  logic                     eoc_clr,
  input  logic                     eoc_ie,
  input  logic                     ovr_clr,
  input  logic                     cmp_in,
  output logic [$clog2(NCH)-1:0]   chan_out,
  output logic [W-1:0]             dac_code,
  output logic                     sample_o,
  output logic                     busy,
  output logic                     eoc_flag,
  output logic                     eoc_irq,
  output logic [W-1:0]             data_out,
  output logic [$clog2(NCH)-1:0]   data_ch,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [W-1:0]             res_data,
  output logic [$clog2(NCH)-1:0]   res_ch,
  output logic                     ovr_flag
);

  localparam int CHW = $clog2(NCH);

  logic           tick, start, go, done, buf_full, eoc_set;
  logic           running, run_n, chg;
  logic [CHW-1:0] cur_ch, nxt_ch, chan_q, top_eff, first_ch;
  logic [CHW:0]   ring_len;
  logic [W-1:0]   result;

  adc_clk_div u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .speed_sel (speed_sel),
    .tick      (tick)
  );

  adc_start_sel u_start (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_start (sw_start),
    .tmr_trig (tmr_trig),
    .ext_pin  (ext_pin),
    .ext_en   (ext_en),
    .ext_src  (ext_src),
    .start    (start)
  );

  adc_sar_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .go       (go),
    .cmp_in   (cmp_in),
    .dac_code (dac_code),
    .sampling (sample_o),
    .done     (done),
    .result   (result)
  );

  assign top_eff  = (chan_sel == '0) ? CHW'(1) : chan_sel;
  assign first_ch = scan_mode ? CHW'(1) : chan_sel;
  assign ring_len = scan_mode ? {1'b0, top_eff} : (CHW+1)'(NCH);
  assign chg      = running && (chan_sel != chan_q);

  always_comb begin
    go     = 1'b0;
    nxt_ch = cur_ch;
    run_n  = running;
    if (!running) begin
      if (start) begin
        go     = 1'b1;
        nxt_ch = first_ch;
        run_n  = 1'b1;
      end
    end else if (chg) begin
      go     = 1'b1;
      nxt_ch = first_ch;
    end else if (done) begin
      if (scan_mode && (cur_ch < top_eff)) begin
        go     = 1'b1;
        nxt_ch = cur_ch + 1'b1;
      end else if (cont_mode) begin
        go     = 1'b1;
        nxt_ch = first_ch;
      end else begin
        run_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cur_ch  <= '0;
      chan_q  <= '0;
    end else begin
      running <= run_n;
      cur_ch  <= nxt_ch;
      chan_q  <= chan_sel;
    end
  end

  adc_result_store #(.W(W), .NCH(NCH), .CHW(CHW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (done),
    .wr_data   (result),
    .wr_ch     (cur_ch),
    .buf_mode  (buf_mode),
    .ring_len  (ring_len),
    .ovr_clr   (ovr_clr),
    .res_ready (res_ready),
    .data_q    (data_out),
    .data_ch_q (data_ch),
    .buf_full  (buf_full),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_ch    (res_ch),
    .ovr       (ovr_flag)
  );

  assign eoc_set = buf_mode ? buf_full : done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       eoc_flag <= 1'b0;
    else if (eoc_set) eoc_flag <= 1'b1;
    else if (eoc_clr) eoc_flag <= 1'b0;
  end

  assign eoc_irq  = eoc_flag & eoc_ie;
  assign chan_out = cur_ch;
  assign busy     = running;

  // R10: the end-of-conversion flag only falls on a clear
  a_r10_eoc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_flag && !eoc_clr) |=> eoc_flag);

  // R4: with no run active the sampling switch stays open
  a_r4_idle_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !sample_o);

  // R9: the multiplexer select moves only on a (re)start
  a_r9_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !go) |=> $stable(chan_out));

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

  localparam int CLK_P  = 10;
  localparam int WD_CYC = 150000;

  // vector: {speed[2:0], channel[3:0], input level[9:0]}
  localparam logic [16:0] VEC [8] = '{
    {3'd0, 4'd0,  10'd0},
    {3'd0, 4'd15, 10'd1023},
    {3'd1, 4'd4,  10'd512},
    {3'd2, 4'd7,  10'd511},
    {3'd0, 4'd9,  10'd341},
    {3'd5, 4'd3,  10'd682},
    {3'd0, 4'd1,  10'd1},
    {3'd7, 4'd12, 10'd1022}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_start = 0, tmr_trig = 0, ext_pin = 0, ext_en = 0, ext_src = 0;
  logic cont_mode = 0, scan_mode = 0, buf_mode = 0;
  logic [3:0] chan_sel = '0;
  logic [2:0] speed_sel = '0;
  logic eoc_clr = 0, eoc_ie = 0, ovr_clr = 0, res_ready = 0;
  logic cmp_in;
  logic [3:0] chan_out, data_ch, res_ch;
  logic [9:0] dac_code, data_out, res_data;
  logic sample_o, busy, eoc_flag, eoc_irq, res_valid, ovr_flag;

  logic [9:0] vin [16];
  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // ideal comparator: input at or above the DAC code
  always_comb cmp_in = (vin[chan_out] >= dac_code);

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .tmr_trig(tmr_trig),
    .ext_pin(ext_pin), .ext_en(ext_en), .ext_src(ext_src),
    .cont_mode(cont_mode), .scan_mode(scan_mode), .buf_mode(buf_mode),
    .chan_sel(chan_sel), .speed_sel(speed_sel), .eoc_clr(eoc_clr),
    .eoc_ie(eoc_ie), .ovr_clr(ovr_clr), .cmp_in(cmp_in),
    .chan_out(chan_out), .dac_code(dac_code), .sample_o(sample_o),
    .busy(busy), .eoc_flag(eoc_flag), .eoc_irq(eoc_irq),
    .data_out(data_out), .data_ch(data_ch), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_ch(res_ch),
    .ovr_flag(ovr_flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_sw();
    @(negedge clk) sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
  endtask

  task automatic clr_eoc();
    @(negedge clk) eoc_clr = 1'b1;
    @(negedge clk) eoc_clr = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic wait_eoc();
    @(negedge clk);
    while (!eoc_flag) @(negedge clk);
  endtask

  task automatic wait_rise();
    while (sample_o) @(negedge clk);
    while (!sample_o) @(negedge clk);
  endtask

  function automatic int div_of(input int code);
    int t [8] = '{2, 3, 4, 6, 8, 10, 12, 18};
    return t[code];
  endfunction

  initial begin
    repeat (WD_CYC) @(posedge clk);
    nfail++;
    $display("FAIL watchdog (R1..R12 run): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) vin[i] = 10'(i * 37 + 5);
    do_reset();

    // R1: reset state
    check("R1 busy", busy, 0);
    check("R1 eoc_flag", eoc_flag, 0);
    check("R1 eoc_irq", eoc_irq, 0);
    check("R1 ovr_flag", ovr_flag, 0);
    check("R1 res_valid", res_valid, 0);
    check("R1 sample_o", sample_o, 0);
    check("R1 data_out", data_out, 0);
    check("R1 dac_code", dac_code, 0);

    // R3 / R4: single conversions from the vector table
    for (int v = 0; v < 8; v++) begin
      speed_sel = VEC[v][16:14];
      chan_sel  = VEC[v][13:10];
      vin[VEC[v][13:10]] = VEC[v][9:0];
      clr_eoc();
      pulse_sw();
      wait_eoc();
      check("R3 result", data_out, VEC[v][9:0]);
      check("R4 channel", data_ch, VEC[v][13:10]);
      check("R4 idle", busy, 0);
    end

    // R2: sampling window is 3 converter clocks
    for (int k = 0; k < 8; k += 3) begin
      int n;
      speed_sel = 3'(k);
      pulse_sw();
      wait_rise();
      n = 0;
      while (sample_o) begin n++; @(negedge clk); end
      check("R2 sample width", n, 3 * div_of(k));
      wait_idle();
    end

    // R5: continuous, one conversion every 14 converter clocks
    begin
      int t1;
      speed_sel = 3'd1; chan_sel = 4'd6; cont_mode = 1'b1;
      pulse_sw();
      wait_rise(); t1 = cyc;
      wait_rise();
      check("R5 period", cyc - t1, 14 * 3);
      wait_rise();
      check("R5 still running", busy, 1);
      cont_mode = 1'b0;
      wait_idle();
      check("R5 result", data_out, vin[6]);
    end

    // R6: scan ascending from 1 to top, then stop
    speed_sel = 3'd0; scan_mode = 1'b1; chan_sel = 4'd3;
    pulse_sw();
    for (int c = 1; c <= 3; c++) begin
      wait_rise();
      check("R6 scan order", chan_out, c);
    end
    wait_idle();
    check("R6 last channel", data_ch, 3);
    check("R6 last data", data_out, vin[3]);
    repeat (60) @(negedge clk);
    check("R6 stopped", busy, 0);
    chan_sel = 4'd0;
    pulse_sw();
    wait_idle();
    check("R6 top zero", data_ch, 1);

    // R7: continuous scan wraps to channel 1
    chan_sel = 4'd2; cont_mode = 1'b1;
    pulse_sw();
    for (int c = 0; c < 4; c++) begin
      wait_rise();
      check("R7 wrap order", chan_out, (c % 2) + 1);
    end
    cont_mode = 1'b0;
    wait_idle();
    scan_mode = 1'b0;

    // R8: trigger gating
    chan_sel = 4'd8;
    @(negedge clk) tmr_trig = 1'b1;
    @(negedge clk) tmr_trig = 1'b0;
    repeat (40) @(negedge clk);
    check("R8 timer gated off", busy, 0);
    ext_en = 1'b1; ext_src = 1'b1;
    @(negedge clk) tmr_trig = 1'b1;
    @(negedge clk) tmr_trig = 1'b0;
    repeat (40) @(negedge clk);
    check("R8 timer not selected", busy, 0);
    ext_src = 1'b0;
    @(negedge clk) tmr_trig = 1'b1;
    @(negedge clk) tmr_trig = 1'b0;
    check("R8 timer start", busy, 1);
    wait_idle();
    check("R8 timer result", data_out, vin[8]);
    ext_src = 1'b1;
    @(negedge clk) ext_pin = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 pin start", busy, 1);
    wait_idle();
    ext_pin = 1'b0; ext_en = 1'b0;
    chan_sel = 4'd3;
    pulse_sw();
    repeat (10) @(negedge clk);
    pulse_sw();
    wait_idle();
    repeat (60) @(negedge clk);
    check("R8 start while busy ignored", busy, 0);

    // R9: channel change mid conversion
    vin[2] = 10'd100; vin[5] = 10'd900;
    chan_sel = 4'd2;
    pulse_sw();
    repeat (12) @(negedge clk);
    chan_sel = 4'd5;
    wait_idle();
    check("R9 restart channel", data_ch, 5);
    check("R9 restart data", data_out, 900);

    // R10: sticky flag and interrupt gating
    check("R10 flag set", eoc_flag, 1);
    repeat (20) @(negedge clk);
    check("R10 flag holds", eoc_flag, 1);
    check("R10 irq masked", eoc_irq, 0);
    eoc_ie = 1'b1;
    @(negedge clk);
    check("R10 irq enabled", eoc_irq, 1);
    clr_eoc();
    check("R10 flag cleared", eoc_flag, 0);
    check("R10 irq cleared", eoc_irq, 0);
    eoc_ie = 1'b0;

    // R11: buffered scan, EOC only when ring full, stream in order
    do_reset();
    vin[1] = 10'd11; vin[2] = 10'd222; vin[3] = 10'd1000;
    buf_mode = 1'b1; scan_mode = 1'b1; chan_sel = 4'd3;
    pulse_sw();
    while (data_ch != 4'd2) @(negedge clk);
    check("R11 no early eoc", eoc_flag, 0);
    wait_idle();
    check("R11 eoc when full", eoc_flag, 1);
    for (int c = 1; c <= 3; c++) begin
      check("R11 valid", res_valid, 1);
      check("R11 channel", res_ch, c);
      check("R11 data", res_data, vin[c]);
      res_ready = 1'b1;
      @(negedge clk);
      res_ready = 1'b0;
    end
    check("R11 drained", res_valid, 0);

    // R12: overrun on wrap over unread slot
    do_reset();
    chan_sel = 4'd2; cont_mode = 1'b1;
    pulse_sw();
    wait_eoc();
    check("R12 no overrun yet", ovr_flag, 0);
    while (!ovr_flag) @(negedge clk);
    check("R12 overrun set", ovr_flag, 1);
    cont_mode = 1'b0;
    wait_idle();
    check("R12 overrun sticky", ovr_flag, 1);
    @(negedge clk) ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
    check("R12 overrun cleared", ovr_flag, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule